// File: doc/BRIEF.md
# Power-Stage Fault Supervisor

This block watches a set of digital fault flags from the analog front end of an off-line switching controller. It decides whether switching may run. Each fault falls into one of two classes. A restartable fault stops switching and waits for the supply to sag. The block then recharges the supply through the high-voltage startup cell and resumes with a fresh soft-start. A locking fault stops switching for good. The supply is still cycled between its turn-off and turn-on levels, but switching does not resume until the supply collapses below a deep release level.

Some faults act at once: supply overvoltage, supply undervoltage and overtemperature. Three others must persist for a blanking window counted in clock cycles. Feedback overload is counted in any gate phase. Output overvoltage on the zero-crossing sense is counted only while the gate is off. Excess current-sense level is counted only while the gate is on. Each window has its own counter. A counter restarts when its condition drops, when its gate phase no longer matches, or when switching is not running.

Top module: `prot_supervisor`

## Requirements
- R1: After reset the block is in the charging state: `cell_en`=1, `sw_en`=0, `restart_req`=0.
- R2: In the charging state, `vcc_on_lvl`=1 at a clock edge starts switching. After that edge `sw_en`=1 and `cell_en`=0, and `restart_req` is 1 for exactly one cycle.
- R3: While switching, any of `vcc_ovp`, `vcc_uvlo` or `over_temp` at a clock edge clears `sw_en` after that edge, and the restartable stop is entered.
- R4: `fb_overload` stops switching only after being sampled high on OLP_CYC consecutive edges while switching. A shorter run has no effect.
- R5: `zc_ovp` counts only on edges with `gate_on`=0. It locks the block after OVP_CYC consecutive such edges. An edge with `gate_on`=1 restarts the count.
- R6: `cs_short` counts only on edges with `gate_on`=1. It locks the block after SCW_CYC consecutive such edges. An edge with `gate_on`=0 restarts the count.
- R7: After a restartable stop, `vcc_uvlo` turns on `cell_en`. A following `vcc_on_lvl` resumes switching with a `restart_req` pulse.
- R8: While locked, `vcc_uvlo` turns `cell_en` on and `vcc_on_lvl` turns it off again. `sw_en` stays 0 throughout, and all other fault flags have no effect.
- R9: A locked block is released only by `vcc_deep_low`. It then enters the charging state (`cell_en`=1), from which `vcc_on_lvl` resumes switching.
- R10: If a locking trip and a restartable fault occur at the same edge, the block locks.
- R11: `sw_en` and `cell_en` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ovp | input | 1 | Supply above overvoltage limit |
| vcc_uvlo | input | 1 | Supply below turn-off level |
| vcc_on_lvl | input | 1 | Supply reached turn-on level |
| vcc_deep_low | input | 1 | Supply below lock release level |
| fb_overload | input | 1 | Feedback above overload level |
| zc_ovp | input | 1 | Zero-crossing sense above output overvoltage level |
| cs_short | input | 1 | Current sense above short-winding level |
| over_temp | input | 1 | Junction overtemperature |
| gate_on | input | 1 | Power switch gate is on |
| sw_en | output | 1 | Switching permitted |
| cell_en | output | 1 | Startup charging cell enabled |
| restart_req | output | 1 | One-cycle soft-start request |

## Verification
The interesting collision is a short-winding window completing on the same edge that an overtemperature flag rises. Both fault classes then request a stop at once. The bench first holds `cs_short` with the gate on for one cycle less than the window. It then raises `over_temp` on the final counting edge. The result is judged after the next undervoltage/turn-on supply cycle: a locked block keeps `sw_en` low, while a wrongly restarted one would raise `sw_en` and `restart_req`.

// File: rtl/prot_sup_pkg.sv
package prot_sup_pkg;

    typedef enum logic [2:0] {
        ST_CHARGE  = 3'd0,
        ST_RUN     = 3'd1,
        ST_ARST    = 3'd2,
        ST_LK_DRN  = 3'd3,
        ST_LK_CHG  = 3'd4
    } sup_state_t;

    typedef struct packed {
        logic restartable;
        logic locking;
    } fault_req_t;

    typedef struct packed {
        logic deep_low;
        logic on_lvl;
        logic uvlo;
    } supply_t;

    function automatic logic is_locked(input sup_state_t s);
        return (s == ST_LK_DRN) || (s == ST_LK_CHG);
    endfunction

    function automatic logic cell_on(input sup_state_t s);
        return (s == ST_CHARGE) || (s == ST_LK_CHG);
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/blank_timer.sv
module blank_timer #(
    parameter int unsigned N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic qual,
    output logic trip
);
    import prot_sup_pkg::*;

    localparam int unsigned CW  = cnt_width(N);
    localparam logic [CW-1:0] LIM = CW'(N - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!qual) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign trip = qual && (cnt == LIM);

    generate
        if (N > 1) begin : g_chk
            // R4 R5 R6: a trip needs the condition on the previous edge too
            p_trip_held_r4: assert property (@(posedge clk) disable iff (rst)
                trip |-> $past(qual));
        end
    endgenerate

endmodule

// File: rtl/fault_classifier.sv
module fault_classifier #(
    parameter int unsigned OLP_CYC = 24000,
    parameter int unsigned OVP_CYC = 100,
    parameter int unsigned SCW_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       gate_on,
    input  logic       vcc_ovp,
    input  logic       vcc_uvlo,
    input  logic       fb_overload,
    input  logic       zc_ovp,
    input  logic       cs_short,
    input  logic       over_temp,
    output prot_sup_pkg::fault_req_t req
);
    import prot_sup_pkg::*;

    logic olp_trip, ovp_trip, scw_trip;
    logic olp_q, ovp_q, scw_q;

    assign olp_q = run && fb_overload;
    assign ovp_q = run && zc_ovp && !gate_on;
    assign scw_q = run && cs_short && gate_on;

    blank_timer #(.N(OLP_CYC)) u_olp (.clk(clk), .rst(rst), .qual(olp_q), .trip(olp_trip));
    blank_timer #(.N(OVP_CYC)) u_ovp (.clk(clk), .rst(rst), .qual(ovp_q), .trip(ovp_trip));
    blank_timer #(.N(SCW_CYC)) u_scw (.clk(clk), .rst(rst), .qual(scw_q), .trip(scw_trip));

    always_comb begin
        req.locking     = ovp_trip || scw_trip;
        req.restartable = run && (vcc_ovp || vcc_uvlo || over_temp || olp_trip);
    end

    // R5: output overvoltage never trips while the gate is on
    p_ovp_phase_r5: assert property (@(posedge clk) disable iff (rst)
        (ovp_trip) |-> !gate_on);
    // R6: short winding never trips while the gate is off
    p_scw_phase_r6: assert property (@(posedge clk) disable iff (rst)
        (scw_trip) |-> gate_on);

endmodule

// File: rtl/supervisor_fsm.sv
module supervisor_fsm (
    input  logic                     clk,
    input  logic                     rst,
    input  prot_sup_pkg::fault_req_t req,
    input  prot_sup_pkg::supply_t    sup,
    output logic                     sw_en,
    output logic                     cell_en,
    output logic                     restart_req
);
    import prot_sup_pkg::*;

    sup_state_t state, nxt;
    logic       rq_q;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_CHARGE: if (sup.on_lvl) nxt = ST_RUN;
            ST_RUN: begin
                if (req.locking)          nxt = ST_LK_DRN;
                else if (req.restartable) nxt = ST_ARST;
            end
            ST_ARST:   if (sup.uvlo) nxt = ST_CHARGE;
            ST_LK_DRN: begin
                if (sup.deep_low)  nxt = ST_CHARGE;
                else if (sup.uvlo) nxt = ST_LK_CHG;
            end
            ST_LK_CHG: begin
                if (sup.deep_low)    nxt = ST_CHARGE;
                else if (sup.on_lvl) nxt = ST_LK_DRN;
            end
            default: nxt = ST_CHARGE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CHARGE;
            rq_q  <= 1'b0;
        end else begin
            state <= nxt;
            rq_q  <= (state == ST_CHARGE) && (nxt == ST_RUN);
        end
    end

    assign sw_en       = (state == ST_RUN);
    assign cell_en     = cell_on(state);
    assign restart_req = rq_q;

    // R11: switching and charging never overlap
    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(sw_en && cell_en));
    // R2: restart request lasts one cycle and coincides with switching
    p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        restart_req |-> sw_en ##1 !restart_req);
    // R10: a locking trip while switching always locks
    p_lock_prio_r10: assert property (@(posedge clk) disable iff (rst)
        (sw_en && req.locking) |=> is_locked(state));
    // R9: only a deep supply collapse leaves the locked states
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (is_locked(state) && !sup.deep_low) |=> is_locked(state));
    // R3: restartable fault stops switching on the next cycle
    p_arst_stop_r3: assert property (@(posedge clk) disable iff (rst)
        (sw_en && req.restartable) |=> !sw_en);

endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor #(
    parameter int unsigned OLP_CYC = 24000,
    parameter int unsigned OVP_CYC = 100,
    parameter int unsigned SCW_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic vcc_ovp,
    input  logic vcc_uvlo,
    input  logic vcc_on_lvl,
    input  logic vcc_deep_low,
    input  logic fb_overload,
    input  logic zc_ovp,
    input  logic cs_short,
    input  logic over_temp,
    input  logic gate_on,
    output logic sw_en,
    output logic cell_en,
    output logic restart_req
);
    import prot_sup_pkg::*;

    fault_req_t req;
    supply_t    sup;

    assign sup.deep_low = vcc_deep_low;
    assign sup.on_lvl   = vcc_on_lvl;
    assign sup.uvlo     = vcc_uvlo;

    fault_classifier #(
        .OLP_CYC(OLP_CYC), .OVP_CYC(OVP_CYC), .SCW_CYC(SCW_CYC)
    ) u_cls (
        .clk(clk), .rst(rst), .run(sw_en), .gate_on(gate_on),
        .vcc_ovp(vcc_ovp), .vcc_uvlo(vcc_uvlo), .fb_overload(fb_overload),
        .zc_ovp(zc_ovp), .cs_short(cs_short), .over_temp(over_temp),
        .req(req)
    );

    supervisor_fsm u_fsm (
        .clk(clk), .rst(rst), .req(req), .sup(sup),
        .sw_en(sw_en), .cell_en(cell_en), .restart_req(restart_req)
    );

endmodule

// File: tb/sim_prot_supervisor.sv
module sim_prot_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int OLP = 6, OVP = 4, SCW = 3;

    localparam logic [8:0] B_GATE = 9'd1,  B_OTP = 9'd2,  B_CS = 9'd4,
                           B_ZC   = 9'd8,  B_FB  = 9'd16, B_VOVP = 9'd32,
                           B_UV   = 9'd64, B_ON  = 9'd128, B_DEEP = 9'd256;
    // expected {sw_en, cell_en, restart_req}
    localparam logic [2:0] E_CHG = 3'b010, E_RUN = 3'b100, E_RQ = 3'b101, E_OFF = 3'b000;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } item_t;

    logic clk = 0, rst = 1;
    logic [8:0] din = '0;
    logic sw_en, cell_en, restart_req;
    item_t q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_supervisor #(.OLP_CYC(OLP), .OVP_CYC(OVP), .SCW_CYC(SCW)) u0 (
        .clk(clk), .rst(rst),
        .vcc_ovp(din[5]), .vcc_uvlo(din[6]), .vcc_on_lvl(din[7]),
        .vcc_deep_low(din[8]), .fb_overload(din[4]), .zc_ovp(din[3]),
        .cs_short(din[2]), .over_temp(din[1]), .gate_on(din[0]),
        .sw_en(sw_en), .cell_en(cell_en), .restart_req(restart_req)
    );

    task automatic drive(input logic [8:0] v, input logic [2:0] e, input string tag);
        item_t it;
        din = v;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic rep(input int n, input logic [8:0] v, input logic [2:0] e, input string tag);
        for (int i = 0; i < n; i++) drive(v, e, tag);
    endtask

    // monitor: sample a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                item_t it;
                logic [2:0] act;
                it  = q.pop_front();
                act = {sw_en, cell_en, restart_req};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got sw/cell/rq=%b expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R1 reset state
        drive(0, E_CHG, "R1");
        // R2 start
        drive(B_ON, E_RQ, "R2");
        drive(0, E_RUN, "R2");
        // R4 short overload run ignored, full window trips
        rep(OLP-1, B_FB, E_RUN, "R4");
        drive(0, E_RUN, "R4");
        rep(OLP-1, B_FB, E_RUN, "R4");
        drive(B_FB, E_OFF, "R4");
        // R7 restart cycle
        drive(0, E_OFF, "R7");
        drive(B_UV, E_CHG, "R7");
        drive(B_OTP, E_CHG, "R7");
        drive(B_ON, E_RQ, "R7");
        drive(0, E_RUN, "R7");
        // R3 immediate faults
        drive(B_OTP, E_OFF, "R3");
        drive(B_UV, E_CHG, "R3");
        drive(B_ON, E_RQ, "R3");
        drive(B_VOVP, E_OFF, "R3");
        drive(B_UV, E_CHG, "R3");
        drive(B_ON, E_RQ, "R3");
        drive(B_UV, E_OFF, "R3");
        drive(B_UV, E_CHG, "R3");
        drive(B_ON, E_RQ, "R3");
        drive(0, E_RUN, "R3");
        // R6 short winding, gate-off edge restarts count
        rep(SCW-1, B_CS | B_GATE, E_RUN, "R6");
        drive(B_CS, E_RUN, "R6");
        rep(SCW-1, B_CS | B_GATE, E_RUN, "R6");
        drive(B_GATE, E_RUN, "R6");
        rep(SCW-1, B_CS | B_GATE, E_RUN, "R6");
        drive(B_CS | B_GATE, E_OFF, "R6");
        // R8 locked supply cycling
        drive(B_ON | B_OTP | B_FB, E_OFF, "R8");
        drive(B_UV, E_CHG, "R8");
        drive(B_VOVP, E_CHG, "R8");
        drive(B_ON, E_OFF, "R8");
        drive(B_UV, E_CHG, "R8");
        drive(B_ON, E_OFF, "R8");
        // R9 release by deep collapse from drain state
        drive(B_DEEP, E_CHG, "R9");
        drive(B_ON, E_RQ, "R9");
        drive(0, E_RUN, "R9");
        // R5 output overvoltage, gate-on edge restarts count
        rep(OVP-1, B_ZC, E_RUN, "R5");
        drive(B_ZC | B_GATE, E_RUN, "R5");
        rep(OVP-1, B_ZC, E_RUN, "R5");
        drive(B_ZC, E_OFF, "R5");
        // R9 release from charging-while-locked state
        drive(B_ON, E_OFF, "R9");
        drive(B_UV, E_CHG, "R9");
        drive(B_DEEP, E_CHG, "R9");
        drive(B_ON, E_RQ, "R9");
        drive(0, E_RUN, "R9");
        // R10 locking and restartable at the same edge
        rep(SCW-1, B_CS | B_GATE, E_RUN, "R10");
        drive(B_CS | B_GATE | B_OTP, E_OFF, "R10");
        drive(B_UV, E_CHG, "R10");
        drive(B_ON, E_OFF, "R10");
        drive(0, E_OFF, "R10");
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule